// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a small 32-bit processor core that finishes one instruction in every clock cycle. Each cycle it fetches a word at the program counter and splits it into register numbers, an immediate and an operation code. It reads two source registers and runs the ALU, then chooses the next program counter. On the closing clock edge it commits at most one register write or one memory write. The supported operations are unsigned add, unsigned subtract, OR with an immediate, word load, word store and branch when two registers are equal.

The core holds its own instruction memory and data memory. Both are small arrays that write on the clock edge and read combinationally. A loader port fills them while the core is held in reset. Two observation ports read any register and any data word without disturbing execution. This lets a checker follow the architectural state one instruction at a time.

The decoder maps every fetched word onto a named instruction class. That class drives a control bundle: register write enable, destination choice (rd or rt), second-operand choice (register or immediate), extension mode, write-back source, memory write enable, branch flag and ALU operation. Any word outside the six supported encodings falls into the no-op class.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0. No register write and no data-memory write from instruction execution takes place.
- R2: An R-type word (bits 31:26 = 0x00, shamt bits 10:6 = 0, funct bits 5:0 = 0x21) writes register rd (bits 15:11) with rs (bits 25:21) plus rt (bits 20:16), modulo 2^32.
- R3: An R-type word with shamt 0 and funct 0x23 writes rd with rs minus rt, modulo 2^32.
- R4: Opcode 0x0D writes rt with rs OR the zero-extended imm16 (bits 15:0). Immediate bit 15 never reaches bits 31:16.
- R5: Opcode 0x23 writes rt with the data word at byte address rs + sign-extended imm16. The word index is address bits 7:2 for the default 64-word memory.
- R6: Opcode 0x2B stores rt into the data word at rs + sign-extended imm16 on the clock edge that ends the instruction. The stored value is visible to the next instruction.
- R7: Opcode 0x04 sets the next program counter to PC + 4 + (sign-extended imm16 << 2) when rs equals rt, and to PC + 4 otherwise. It writes no register.
- R8: Every instruction other than a taken branch advances the program counter by 4.
- R9: Register 0 always reads as zero, and a write aimed at it is discarded.
- R10: Any other word is a no-op that writes no register and no memory. This covers other opcodes, other funct values, and an add or subtract with nonzero shamt.
- R11: When an instruction names the same register as source and destination, it reads the value held before that instruction.
- R12: The loader ports write instruction and data words by word index on a clock edge. The peek ports return a register value and a data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Instruction memory load strobe |
| prog_addr | input | 6 | Instruction word index to load |
| prog_data | input | 32 | Instruction word to load |
| mem_ld_we | input | 1 | Data memory load strobe (wins over a store) |
| mem_ld_addr | input | 6 | Data word index to load or peek |
| mem_ld_data | input | 32 | Data word to load |
| mem_peek_data | output | 32 | Data word at `mem_ld_addr` |
| reg_peek_addr | input | 5 | Register number to observe |
| reg_peek_data | output | 32 | Value of register `reg_peek_addr` |
| pc | output | 32 | Current program counter |

## Verification
Each program exercises one family of operations, and a reference model predicts the state after every instruction.

- **Arithmetic:** immediates with bit 15 set separate zero extension from sign extension. A subtraction that goes negative shows wrap-around. Writes to register 0 and same-register source and destination show discard and read-old-value behaviour.
- **Memory:** loads and stores use positive and negative offsets from a base register, so a wrong extension mode lands on a different word. A load that follows a store to the same word shows that the write commits on the edge.
- **Branches:** a counted backward loop and a forward exit separate taken from not-taken target arithmetic.
- **No-ops:** unsupported opcodes, funct values and a nonzero shamt show that nothing is written.
- **Reset:** a store is held at address 0 under reset to show that reset suppresses writes.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_OR
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_NOP,
        CL_ADDU,
        CL_SUBU,
        CL_ORI,
        CL_LW,
        CL_SW,
        CL_BEQ
    } iclass_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    ext_signed;
        logic    wb_from_mem;
        logic    mem_we;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    iclass_e cls;

    // classify the fetched word
    always_comb begin
        cls = CL_NOP;
        if (op == OP_RTYPE && shamt == 5'd0) begin
            if (funct == FN_ADDU)      cls = CL_ADDU;
            else if (funct == FN_SUBU) cls = CL_SUBU;
        end else if (op == OP_ORI) begin
            cls = CL_ORI;
        end else if (op == OP_LW) begin
            cls = CL_LW;
        end else if (op == OP_SW) begin
            cls = CL_SW;
        end else if (op == OP_BEQ) begin
            cls = CL_BEQ;
        end
    end

    // control bundle per class
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, ext_signed: 1'b0,
                 wb_from_mem: 1'b0, mem_we: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD};
        unique case (cls)
            CL_ADDU: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            CL_SUBU: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            CL_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            CL_LW: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.ext_signed  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.alu_op      = ALU_ADD;
            end
            CL_SW: begin
                ctrl.mem_we     = 1'b1;
                ctrl.b_is_imm   = 1'b1;
                ctrl.ext_signed = 1'b1;
                ctrl.alu_op     = ALU_ADD;
            end
            CL_BEQ: begin
                ctrl.is_branch  = 1'b1;
                ctrl.ext_signed = 1'b1;
                ctrl.alu_op     = ALU_SUB;
            end
            CL_NOP: begin
                ctrl.reg_we = 1'b0;
            end
            default: begin
                ctrl.reg_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    ra1,
    input  logic [AW-1:0]    ra2,
    input  logic [AW-1:0]    ra3,
    output logic [WIDTH-1:0] rd1,
    output logic [WIDTH-1:0] rd2,
    output logic [WIDTH-1:0] rd3
);

    logic [WIDTH-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // reads see the value from before this cycle's write; entry 0 reads zero
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IA_W      = $clog2(IMEM_WORDS),
    localparam int DA_W      = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_we,
    input  logic [IA_W-1:0] prog_addr,
    input  logic [31:0]     prog_data,
    input  logic            mem_ld_we,
    input  logic [DA_W-1:0] mem_ld_addr,
    input  logic [31:0]     mem_ld_data,
    output logic [31:0]     mem_peek_data,
    input  logic [4:0]      reg_peek_addr,
    output logic [31:0]     reg_peek_data,
    output logic [31:0]     pc
);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] instr;
    logic [4:0]  rs_idx, rt_idx, rd_idx, dst_idx;
    logic [15:0] imm16;
    logic [31:0] ext_imm, rs_data, rt_data, alu_b, alu_y, wb_data, dm_rdata;
    logic [31:0] pc_seq, pc_next;
    logic        alu_zero, rf_we, dm_we;
    ctrl_t       ctrl;

    // fetch and field split
    assign instr  = imem[pc[IA_W+1:2]];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign imm16  = instr[15:0];

    sc_decode u_dec (
        .op    (instr[31:26]),
        .shamt (instr[10:6]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    assign ext_imm = ctrl.ext_signed ? {{16{imm16[15]}}, imm16} : {16'h0000, imm16};
    assign dst_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign rf_we   = ctrl.reg_we & ~rst;
    assign dm_we   = ctrl.mem_we & ~rst;

    sc_regfile #(.NREG(32), .WIDTH(32)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (dst_idx),
        .wdata (wb_data),
        .ra1   (rs_idx),
        .ra2   (rt_idx),
        .ra3   (reg_peek_addr),
        .rd1   (rs_data),
        .rd2   (rt_data),
        .rd3   (reg_peek_data)
    );

    assign alu_b = ctrl.b_is_imm ? ext_imm : rt_data;

    sc_alu #(.WIDTH(32)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_data),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_rdata      = dmem[alu_y[DA_W+1:2]];
    assign wb_data       = ctrl.wb_from_mem ? dm_rdata : alu_y;
    assign mem_peek_data = dmem[mem_ld_addr];

    // next program counter
    assign pc_seq  = pc + 32'd4;
    assign pc_next = (ctrl.is_branch && alu_zero) ? pc_seq + {ext_imm[29:0], 2'b00} : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    // memories write on the edge; the address is settled by then
    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    always_ff @(posedge clk) begin
        if (mem_ld_we)  dmem[mem_ld_addr] <= mem_ld_data;
        else if (dm_we) dmem[alu_y[DA_W+1:2]] <= rt_data;
    end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_data,
    input logic [31:0] rt_data,
    input logic        rf_we,
    input logic        dm_we
);

    logic       rst_q;
    logic [5:0] op;
    logic       legal;

    assign op    = instr[31:26];
    assign legal = (op == 6'h00 && instr[10:6] == 5'd0 &&
                    (instr[5:0] == 6'h21 || instr[5:0] == 6'h23)) ||
                   op == 6'h0D || op == 6'h23 || op == 6'h2B || op == 6'h04;

    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q == 1'b1) AST_PC_RESET: assert (pc == 32'd0); // R1
        if (rst == 1'b1) AST_QUIET_IN_RESET: assert (!rf_we && !dm_we); // R1
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (op != 6'h04) |=> (pc == $past(pc) + 32'd4)); // R8

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h04 && rs_data == rt_data) |=>
        (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00})); // R7

    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h04 && rs_data != rt_data) |=> (pc == $past(pc) + 32'd4)); // R7

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == 5'd0) |-> (rs_data == 32'd0)); // R9

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !legal |-> (!rf_we && !dm_we)); // R10

endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc),
    .instr   (instr),
    .rs_idx  (rs_idx),
    .rs_data (rs_data),
    .rt_data (rt_data),
    .rf_we   (rf_we),
    .dm_we   (dm_we)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

    localparam int NW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic        mem_ld_we = 1'b0;
    logic [5:0]  mem_ld_addr = '0;
    logic [31:0] mem_ld_data = '0;
    logic [31:0] mem_peek_data;
    logic [4:0]  reg_peek_addr = '0;
    logic [31:0] reg_peek_data;
    logic [31:0] pc;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] prog   [NW];
    logic [31:0] refreg [32];
    logic [31:0] refmem [NW];
    logic [31:0] refpc;

    always #4 clk = ~clk;

    sc_core u_dut (
        .clk(clk), .rst(rst),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .mem_ld_we(mem_ld_we), .mem_ld_addr(mem_ld_addr), .mem_ld_data(mem_ld_data),
        .mem_peek_data(mem_peek_data),
        .reg_peek_addr(reg_peek_addr), .reg_peek_data(reg_peek_data),
        .pc(pc)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input int sh, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model of one instruction; returns the register named by the word
    task automatic model_step(output logic [4:0] chk, output string req);
        logic [31:0] w, a, b, sx, zx, addr;
        logic [5:0]  op;
        w    = prog[refpc[7:2]];
        op   = w[31:26];
        a    = refreg[w[25:21]];
        b    = refreg[w[20:16]];
        sx   = {{16{w[15]}}, w[15:0]};
        zx   = {16'h0, w[15:0]};
        addr = a + sx;
        chk  = (op == 6'h00) ? w[15:11] : w[20:16];
        req  = "R10";
        refpc = refpc + 32'd4;
        if (op == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h21) begin
            refreg[w[15:11]] = a + b; req = "R2";
        end else if (op == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h23) begin
            refreg[w[15:11]] = a - b; req = "R3";
        end else if (op == 6'h0D) begin
            refreg[w[20:16]] = a | zx; req = "R4";
        end else if (op == 6'h23) begin
            refreg[w[20:16]] = refmem[addr[7:2]]; req = "R5";
        end else if (op == 6'h2B) begin
            refmem[addr[7:2]] = b; req = "R6";
        end else if (op == 6'h04) begin
            if (a == b) refpc = refpc + {sx[29:0], 2'b00};
            req = "R7";
        end
        refreg[0] = 32'd0;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < NW; i++) prog[i] = 32'd0;
    endtask

    // under reset: push program, zero model registers
    task automatic load_prog();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NW; i++) begin
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        for (int i = 0; i < 32; i++) refreg[i] = 32'd0;
        refpc = 32'd0;
    endtask

    task automatic load_word(input int idx, input logic [31:0] v);
        mem_ld_we = 1'b1; mem_ld_addr = 6'(idx); mem_ld_data = v;
        @(negedge clk);
        mem_ld_we = 1'b0;
        refmem[idx] = v;
    endtask

    task automatic run_steps(input int n);
        logic [4:0] r;
        string req;
        rst = 1'b0;
        for (int s = 0; s < n; s++) begin
            model_step(r, req);
            @(posedge clk);
            #2;
            reg_peek_addr = r;
            #1;
            check("R8", "pc", pc, refpc);
            check(req, $sformatf("reg %0d", r), reg_peek_data, refreg[r]);
            @(negedge clk);
        end
    endtask

    // program is followed by no-ops, so state is stable while sweeping
    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            reg_peek_addr = 5'(i); #0.2;
            check(req, $sformatf("sweep reg %0d", i), reg_peek_data, refreg[i]);
        end
        for (int i = 0; i < 16; i++) begin
            mem_ld_addr = 6'(i); #0.2;
            check(req, $sformatf("sweep mem %0d", i), mem_peek_data, refmem[i]);
        end
    endtask

    task automatic t_arith();
        clear_prog();
        prog[0] = enc_i(6'h0D, 0, 1, 16'h1234);
        prog[1] = enc_i(6'h0D, 0, 2, 16'h8005);      // R4 zero extension
        prog[2] = enc_i(6'h0D, 2, 2, 16'h0F00);
        prog[3] = enc_r(1, 2, 3, 0, 6'h21);          // R2
        prog[4] = enc_r(1, 2, 4, 0, 6'h23);          // R3 negative wrap
        prog[5] = enc_r(1, 2, 0, 0, 6'h21);          // R9 write to r0
        prog[6] = enc_r(1, 1, 1, 0, 6'h21);          // R11 same source/dest
        prog[7] = enc_r(4, 0, 5, 0, 6'h23);          // R9 r0 reads zero
        load_prog();
        run_steps(8);
        check("R4", "r2 upper zero", refreg[2] & 32'hFFFF0000, 32'd0);
        reg_peek_addr = 5'd1; #0.2;
        check("R11", "r1 doubled once", reg_peek_data, 32'h2468);
        reg_peek_addr = 5'd0; #0.2;
        check("R9", "r0 still zero", reg_peek_data, 32'd0);
        sweep("R2");
    endtask

    task automatic t_mem();
        clear_prog();
        prog[0] = enc_i(6'h0D, 0, 6, 16'h0018);
        prog[1] = enc_i(6'h23, 6, 7, 16'hFFF0);      // R5 lw, -16
        prog[2] = enc_i(6'h23, 6, 8, 16'hFFFC);      // R5 lw, -4
        prog[3] = enc_i(6'h2B, 6, 7, 16'h0004);      // R6 sw -> word 7
        prog[4] = enc_i(6'h23, 0, 9, 16'h001C);      // R6 read back
        prog[5] = enc_i(6'h2B, 0, 8, 16'h0000);      // R6 sw -> word 0
        load_prog();
        for (int i = 0; i < 16; i++) load_word(i, 32'h1000_0000 + 32'(i)); // R12
        load_word(2, 32'hDEADBEEF);
        load_word(5, 32'h0BADF00D);
        run_steps(6);
        reg_peek_addr = 5'd9; #0.2;
        check("R6", "load after store", reg_peek_data, 32'hDEADBEEF);
        sweep("R5");
    endtask

    task automatic t_branch();
        clear_prog();
        prog[0] = enc_i(6'h0D, 0, 1, 16'h0001);
        prog[1] = enc_i(6'h0D, 0, 2, 16'h0003);
        prog[2] = enc_r(3, 1, 3, 0, 6'h21);
        prog[3] = enc_i(6'h04, 3, 2, 16'h0001);      // R7 exit when equal
        prog[4] = enc_i(6'h04, 0, 0, 16'hFFFD);      // R7 backward
        prog[5] = enc_i(6'h04, 1, 2, 16'h0002);      // R7 not taken
        prog[6] = enc_i(6'h0D, 0, 4, 16'h0077);
        load_prog();
        run_steps(12);
        check("R7", "final pc", pc, 32'd28);
        reg_peek_addr = 5'd3; #0.2;
        check("R7", "loop count", reg_peek_data, 32'd3);
        sweep("R7");
    endtask

    task automatic t_nop();
        clear_prog();
        prog[0] = enc_i(6'h0D, 0, 1, 16'h0005);
        prog[1] = enc_i(6'h3F, 0, 1, 16'h00FF);      // R10 unknown opcode
        prog[2] = enc_r(1, 1, 2, 0, 6'h20);          // R10 other funct
        prog[3] = enc_r(1, 1, 3, 4, 6'h21);          // R10 nonzero shamt
        prog[4] = {6'h02, 26'h0000010};              // R10 jump-like word
        prog[5] = enc_i(6'h2A, 0, 1, 16'h0008);      // R10 store-like word
        load_prog();
        for (int i = 0; i < 16; i++) load_word(i, 32'h5A5A_0000 + 32'(i));
        run_steps(6);
        sweep("R10");
    endtask

    task automatic t_reset();
        clear_prog();
        prog[0] = enc_i(6'h2B, 0, 0, 16'h000C);      // would clear word 3
        load_prog();
        load_word(3, 32'hAAAA5555);
        repeat (4) @(negedge clk);
        #1;
        check("R1", "pc in reset", pc, 32'd0);
        mem_ld_addr = 6'd3; #0.2;
        check("R1", "no store in reset", mem_peek_data, 32'hAAAA5555);
        reg_peek_addr = 5'd1; #0.2;
        check("R1", "regs cleared", reg_peek_data, 32'd0);
        reg_peek_addr = 5'd7; #0.2;
        check("R1", "regs cleared r7", reg_peek_data, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) refmem[i] = 32'd0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "pc after reset", pc, 32'd0);
        t_arith();
        t_mem();
        t_branch();
        t_nop();
        t_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule